// File: doc/BRIEF.md
# Double-Buffered Stream Write Controller

This block takes video pixels from a stream input and hands them to memory in fixed-size bursts. The stream input is never back-pressured. Incoming beats fill one of two small ping-pong buffers. Each buffer holds exactly one burst. A main state machine waits for a full buffer, issues one burst write on a simple memory-side handshake (address request, data beats, write response) and hands the buffer back to the writer only once the response has come back.

While pixels arrive, the block measures each line and each frame. A line is closed by the end-of-line flag, and a frame is opened by the start-of-frame flag. Both counts are compared with the configured width and height. A mismatch raises a sticky frame error. If the writer fills a buffer while the other one is still held by the memory side, it drops the burst it just collected, refills the same buffer and raises a sticky congestion error. A configuration bit decides what happens at the end of a burst when an error is pending: the block either stops draining until an explicit restart, or it carries on.

Top module: `dbuf_stream_writer`

## Requirements
- R1: `s_tready` is 1 in every cycle, including during reset.
- R2: After reset, `m_req_valid`, `m_wvalid`, `burst_done`, `err_congest`, `err_frame` and `halted` are all 0.
- R3: Once BURST_LEN beats have been stored in a buffer, the block issues exactly one request. Its address is BASE_ADDR + n·BURST_LEN·(DATA_W/8), where n counts the bursts completed since reset. The request is followed by BURST_LEN data beats in arrival order, with `m_wlast` set on the final beat only.
- R4: The two buffers are filled alternately and drained in the order they were filled, so consecutive bursts carry consecutive stream data.
- R5: A buffer is released only when the write response (`m_bvalid` while `m_bready`) is received. `burst_done` is a one-cycle pulse that follows each response, and there is none before it.
- R6: If a buffer becomes full while the other buffer has not yet been released, that burst is discarded and the writer refills the same buffer. `err_congest` goes to 1 and stays there, and no request is issued for the discarded data.
- R7: A beat with `s_tlast` = 1 whose position in its line (counting from 1, where the line starts after the previous `s_tlast` or at a beat with `s_tuser` = 1) differs from `cfg_width` sets `err_frame`.
- R8: A beat with `s_tuser` = 1 that arrives after a previous start-of-frame sets `err_frame` if the number of `s_tlast` beats since that previous start-of-frame differs from `cfg_height`.
- R9: With `cfg_halt` = 1 and an error pending at the end of a burst, the block enters its error state (`halted` = 1). In that state it issues no requests, even for full buffers, until `restart` is pulsed.
- R10: A `restart` pulse clears both error flags, clears the frame-size tracking and returns a halted block to draining. With `cfg_halt` = 0, errors never stop draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream ready, tied high |
| s_tdata | input | DATA_W | Stream pixel data |
| s_tuser | input | 1 | Start of frame |
| s_tlast | input | 1 | End of line |
| cfg_width | input | DIM_W | Expected beats per line |
| cfg_height | input | DIM_W | Expected lines per frame |
| cfg_halt | input | 1 | Stop at burst end when an error is pending |
| restart | input | 1 | Clear errors and tracking, leave the error state |
| m_req_valid | output | 1 | Burst request valid |
| m_req_ready | input | 1 | Burst request accepted |
| m_req_addr | output | ADDR_W | Burst byte address |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data accepted |
| m_wdata | output | DATA_W | Write data |
| m_wlast | output | 1 | Last beat of the burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response accepted |
| burst_done | output | 1 | One-cycle pulse after each burst response |
| err_congest | output | 1 | Sticky buffer contention error |
| err_frame | output | 1 | Sticky frame size error |
| halted | output | 1 | Block is in its error state |

## Verification
The bench uses the default parameters: 32-bit data, 16-beat bursts, 12-bit dimensions and base address 0. With these values a burst takes 64 bytes, and the frame shapes in the table (16×2, 15×2, 16×3, 8×4, 8×3) hit line and frame ends both on and off buffer boundaries. Because bursts are short, the memory model can hold back a single response and cause contention within two bursts. A halt can then be observed with a third buffer waiting in the wings, so discarded-data and restart behaviour are both seen at the ports.

// File: rtl/dbuf_stream_writer.sv
module dbuf_stream_writer #(
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 16,
  parameter int ADDR_W    = 32,
  parameter int DIM_W     = 12,
  parameter int BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tuser,
  input  logic              s_tlast,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic              cfg_halt,
  input  logic              restart,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic              burst_done,
  output logic              err_congest,
  output logic              err_frame,
  output logic              halted
);

  localparam int IDX_W       = $clog2(BURST_LEN);
  localparam int BURST_BYTES = BURST_LEN * (DATA_W / 8);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

  typedef enum logic [2:0] {ST_RESET, ST_IDLE, ST_READ, ST_DONE, ST_ERROR} state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_RESP} phase_t;

  state_t             state;
  phase_t             ph;
  logic [DATA_W-1:0]  mem [2*BURST_LEN];
  logic [1:0]         full;
  logic               wr_sel, rd_sel;
  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic [ADDR_W-1:0]  burst_cnt;
  logic [DIM_W-1:0]   col_cnt, line_cnt;
  logic               in_frame;

  logic               beat, wr_last, rel, other_busy, congest;
  logic [DIM_W-1:0]   col_eff, line_base;
  logic               w_bad, h_bad;

  assign s_tready = 1'b1;
  assign beat     = s_tvalid;
  assign wr_last  = beat && (wr_idx == LAST_IDX);
  assign rel      = (state == ST_READ) && (ph == PH_RESP) && m_bvalid;
  assign other_busy = full[!wr_sel] && !(rel && (rd_sel != wr_sel));
  assign congest  = wr_last && other_busy;

  // writer side: buffer fill, ownership, contention
  always_ff @(posedge clk) begin
    if (beat) mem[{wr_sel, wr_idx}] <= s_tdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sel      <= 1'b0;
      wr_idx      <= '0;
      full        <= '0;
      err_congest <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++)
        full[b] <= (full[b] && !(rel && (rd_sel == 1'(b)))) ||
                   (wr_last && !other_busy && (wr_sel == 1'(b)));
      wr_idx      <= wr_last ? '0 : wr_idx + IDX_W'(beat);
      if (wr_last && !other_busy) wr_sel <= !wr_sel;
      err_congest <= (err_congest && !restart) || congest;
    end
  end

  // frame size tracking
  assign col_eff   = s_tuser ? '0 : col_cnt;
  assign line_base = s_tuser ? '0 : line_cnt;
  assign w_bad = beat && s_tlast && ((col_eff + DIM_W'(1)) != cfg_width);
  assign h_bad = beat && s_tuser && in_frame && (line_cnt != cfg_height);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      col_cnt  <= '0;
      line_cnt <= '0;
      in_frame <= 1'b0;
    end else if (beat) begin
      if (s_tuser) in_frame <= 1'b1;
      if (s_tlast) begin
        col_cnt  <= '0;
        line_cnt <= line_base + DIM_W'(1);
      end else begin
        col_cnt  <= col_eff + DIM_W'(1);
        line_cnt <= line_base;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_frame <= 1'b0;
    else        err_frame <= (err_frame && !restart) || w_bad || h_bad;
  end

  // main state machine: drain full buffers as bursts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RESET;
      ph        <= PH_ADDR;
      rd_sel    <= 1'b0;
      rd_idx    <= '0;
      burst_cnt <= '0;
    end else begin
      case (state)
        ST_RESET: state <= ST_IDLE;
        ST_IDLE: if (full[rd_sel]) begin
          state  <= ST_READ;
          ph     <= PH_ADDR;
          rd_idx <= '0;
        end
        ST_READ: case (ph)
          PH_ADDR: if (m_req_ready) ph <= PH_DATA;
          PH_DATA: if (m_wready) begin
            if (rd_idx == LAST_IDX) ph <= PH_RESP;
            else rd_idx <= rd_idx + IDX_W'(1);
          end
          default: if (m_bvalid) begin
            rd_sel    <= !rd_sel;
            burst_cnt <= burst_cnt + ADDR_W'(1);
            state     <= ST_DONE;
          end
        endcase
        ST_DONE: state <= (cfg_halt && (err_congest || err_frame)) ? ST_ERROR : ST_IDLE;
        ST_ERROR: if (restart) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign m_req_valid = (state == ST_READ) && (ph == PH_ADDR);
  assign m_req_addr  = ADDR_W'(BASE_ADDR) + burst_cnt * ADDR_W'(BURST_BYTES);
  assign m_wvalid    = (state == ST_READ) && (ph == PH_DATA);
  assign m_wdata     = mem[{rd_sel, rd_idx}];
  assign m_wlast     = m_wvalid && (rd_idx == LAST_IDX);
  assign m_bready    = (state == ST_READ) && (ph == PH_RESP);
  assign burst_done  = (state == ST_DONE);
  assign halted      = (state == ST_ERROR);

  a_r5_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(m_bvalid && m_bready));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);
  a_r6_no_write_into_full: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> !full[wr_sel]);
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid && !m_req_ready |=> m_req_valid && $stable(m_req_addr));
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !restart |=> halted && !m_req_valid);
  a_r7_frame_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame && !restart |=> err_frame);

endmodule

// File: tb/tb_dbuf_stream_writer.sv
module tb_dbuf_stream_writer;
  localparam int DW = 32;
  localparam int BL = 16;

  logic clk = 0, rst_n = 0;
  logic s_tvalid = 0, s_tready, s_tuser = 0, s_tlast = 0;
  logic [DW-1:0] s_tdata = '0;
  logic [11:0] cfg_width = 12'd16, cfg_height = 12'd2;
  logic cfg_halt = 0, restart = 0;
  logic m_req_valid, m_req_ready = 1, m_wvalid, m_wready = 1, m_wlast, m_bvalid = 0, m_bready;
  logic [31:0] m_req_addr;
  logic [DW-1:0] m_wdata;
  logic burst_done, err_congest, err_frame, halted;

  dbuf_stream_writer dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] cap [512];
  logic [31:0] req_a [64];
  int cap_n = 0, req_n = 0, done_n = 0, last_n = 0;
  logic resp_hold = 0, pend = 0;

  // frame table: sent width, sent height, cfg width, cfg height, expected error
  localparam int TBL [5][5] = '{
    '{16, 2, 16, 2, 0}, '{15, 2, 16, 2, 1}, '{16, 3, 16, 2, 1},
    '{ 8, 4,  8, 4, 0}, '{ 8, 3,  8, 4, 1}};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        m_bvalid = 0; pend = 0;
      end else begin
        if (m_bvalid) m_bvalid = 0;
        else if (pend && !resp_hold) begin m_bvalid = 1; pend = 0; end
        if (m_wvalid) begin
          cap[cap_n % 512] = m_wdata; cap_n++;
          if (m_wlast) begin last_n++; pend = 1; end
        end
        if (m_req_valid) begin req_a[req_n % 64] = m_req_addr; req_n++; end
        if (burst_done) done_n++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0; s_tvalid = 0; restart = 0;
    repeat (3) @(negedge clk);
    cap_n = 0; req_n = 0; done_n = 0; last_n = 0;
    rst_n = 1;
  endtask

  task automatic send(input logic [31:0] d, input bit u, input bit l);
    @(negedge clk); s_tvalid = 1; s_tdata = d; s_tuser = u; s_tlast = l;
    @(negedge clk); s_tvalid = 0; s_tuser = 0; s_tlast = 0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    chk(s_tready === 1'b1, "R1 ready in reset", s_tready, 1);
    do_reset();
    @(negedge clk);
    chk(s_tready === 1'b1, "R1 ready", s_tready, 1);
    chk({m_req_valid, m_wvalid, burst_done, err_congest, err_frame, halted} === 6'b0,
        "R2 reset state", {m_req_valid, m_wvalid, burst_done, err_congest, err_frame, halted}, 0);

    // basic drain of two buffers
    for (int i = 0; i < 2 * BL; i++) send(32'h100 + i, i == 0, (i % 16) == 15);
    idle(40);
    chk(req_n == 2, "R3 request count", req_n, 2);
    chk(req_a[0] == 0 && req_a[1] == 64, "R3 addresses", req_a[1], 64);
    chk(last_n == 2 && cap_n == 32, "R3 beats and wlast", cap_n, 32);
    begin
      int bad = 0;
      for (int i = 0; i < 2 * BL; i++) if (cap[i] != 32'h100 + i) bad++;
      chk(bad == 0, "R4 data order", bad, 0);
    end
    chk(done_n == 2, "R5 done pulses", done_n, 2);
    chk(err_frame == 0 && err_congest == 0, "R7 no error on good stream", err_frame, 0);
    chk(s_tready === 1'b1, "R1 ready while streaming", s_tready, 1);

    // frame size table
    for (int e = 0; e < 5; e++) begin
      cfg_width = 12'(TBL[e][2]); cfg_height = 12'(TBL[e][3]);
      pulse_restart();
      for (int y = 0; y < TBL[e][1]; y++)
        for (int x = 0; x < TBL[e][0]; x++)
          send(32'(e * 1000 + y * 100 + x), (x == 0 && y == 0), x == TBL[e][0] - 1);
      send(32'hFFFF, 1, 0);
      idle(2);
      chk(err_frame == 1'(TBL[e][4]), e == 1 ? "R7 width check" : "R8 height check",
          err_frame, TBL[e][4]);
      chk(halted == 0, "R10 no halt when cfg_halt=0", halted, 0);
    end
    pulse_restart();
    @(negedge clk);
    chk(err_frame == 0, "R10 restart clears frame error", err_frame, 1'b0);

    // contention
    do_reset();
    cfg_width = 12'd16; cfg_height = 12'd2; resp_hold = 1;
    for (int i = 0; i < BL; i++) send(32'h200 + i, 0, 0);
    idle(30);
    chk(done_n == 0, "R5 no done before response", done_n, 0);
    for (int i = 0; i < BL; i++) send(32'h300 + i, 0, 0);
    @(negedge clk);
    chk(err_congest == 1, "R6 congestion flag", err_congest, 1);
    chk(req_n == 1 && cap_n == 16, "R6 no request for dropped burst", req_n, 1);
    resp_hold = 0;
    idle(6);
    chk(done_n == 1, "R5 done after response", done_n, 1);
    for (int i = 0; i < BL; i++) send(32'h400 + i, 0, 0);
    idle(30);
    begin
      int bad = 0;
      for (int i = 0; i < BL; i++) if (cap[16 + i] != 32'h400 + i) bad++;
      chk(bad == 0 && cap_n == 32, "R6 dropped data never written", bad, 0);
    end
    chk(req_a[1] == 64, "R3 address after contention", req_a[1], 64);
    chk(err_congest == 1, "R6 congestion sticky", err_congest, 1);

    // halt and restart
    do_reset();
    cfg_halt = 1; cfg_width = 12'd16;
    for (int i = 0; i < BL; i++) send(32'h500 + i, 0, i == 3);
    idle(30);
    chk(err_frame == 1 && done_n == 1, "R7 short line flagged", err_frame, 1);
    chk(halted == 1, "R9 halted", halted, 1);
    for (int i = 0; i < BL; i++) send(32'h600 + i, 0, 0);
    idle(20);
    chk(req_n == 1 && cap_n == 16, "R9 no drain while halted", req_n, 1);
    pulse_restart();
    idle(30);
    chk(halted == 0 && err_frame == 0 && err_congest == 0, "R10 restart clears", halted, 0);
    chk(req_n == 2 && cap_n == 32 && cap[16] == 32'h600, "R10 drain resumes", cap_n, 32);
    finish_run();
  end
endmodule